// File: doc/BRIEF.md
# SPI Slave Clock-Activity Watchdog

This block guards a selected SPI slave against a master that stops clocking. While the slave is selected, a down-counter runs on the system clock. Every transition of the serial clock refills the counter from a programmable reload value. If the counter runs out, the block emits a one-cycle timeout pulse. The slave control logic takes that pulse as an abort and returns to idle.

The watchdog runs only when the interface is in slave mode and the watchdog enable bit is set. The serial clock and the select input arrive already synchronized to the system clock. Select is active low. The counter fills from the reload value each time selection begins, so every countdown starts from the full interval. After a timeout the counter stays stopped until the next selection. A reload value of zero turns the timeout off.

Top module: `sck_watchdog`

## Requirements
- R1: While `ss_n_sync` is high, `timeout_pulse` stays 0 whatever `sck_sync` does.
- R2: With `reload_val` = N (N > 0) and no serial-clock transition, `timeout_pulse` rises N system clocks after the clock edge at which selection begins (`ss_n_sync` sampled low after being high).
- R3: A rising transition of `sck_sync` while selected refills the counter with `reload_val`. The next timeout is then N clocks after the edge that samples the transition.
- R4: A falling transition of `sck_sync` while selected refills the counter in the same way as a rising one.
- R5: `timeout_pulse` is high for exactly one clock. After it, serial-clock transitions cause no further pulse until select is released and asserted again.
- R6: When `reload_val` is 0, no timeout is produced.
- R7: When `slave_mode` or `wd_enable` is 0, no timeout is produced and the counter is held at `reload_val`. Enabling while selected starts a full interval of N clocks.
- R8: Releasing select in the middle of a countdown cancels it. The next selection starts a fresh interval of N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 when the interface runs as a slave |
| wd_enable | input | 1 | Control bit that turns on the watchdog function |
| sck_sync | input | 1 | Serial clock, synchronized to `clk` |
| ss_n_sync | input | 1 | Slave select, active low, synchronized to `clk` |
| reload_val | input | 16 | Countdown interval in system clocks; 0 disables the timeout |
| timeout_pulse | output | 1 | One-clock pulse when the master stalls |

## Verification
Every result is registered. The edge that samples a serial-clock transition or the start of selection also reloads the counter. The timeout pulse is visible N edges after that reload, and a disable or release takes effect at the next edge. The bench drives inputs on the falling edge of the clock and samples outputs on the falling edge as well. A behavioural model updates on each rising edge, so the expected value for the output is already settled when it is compared. Directed windows count how many pulses appear and at which cycle the first one appears, so the R2, R7 and R8 interval checks measure the exact N-cycle spacing.

// File: rtl/sckwd_pkg.sv
package sckwd_pkg;

  typedef enum logic [1:0] {
    WD_LOAD = 2'd0,
    WD_HOLD = 2'd1,
    WD_DEC  = 2'd2,
    WD_FIRE = 2'd3
  } wd_act_e;

  // Priority: not running > new selection > stopped after expiry >
  // clock activity > disabled by zero reload > last count > count down.
  function automatic wd_act_e pick_action(
    input logic running,
    input logic starting,
    input logic stopped,
    input logic clk_activity,
    input logic reload_is_zero,
    input logic last_count
  );
    if (!running)            return WD_LOAD;
    else if (starting)       return WD_LOAD;
    else if (stopped)        return WD_HOLD;
    else if (clk_activity)   return WD_LOAD;
    else if (reload_is_zero) return WD_HOLD;
    else if (last_count)     return WD_FIRE;
    else                     return WD_DEC;
  endfunction

endpackage

// File: rtl/sckwd_edges.sv
module sckwd_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic sck_in,
  input  logic ss_n_in,
  output logic running,
  output logic starting,
  output logic sck_toggle
);
  logic sck_prev;
  logic run_prev;

  assign running    = armed & ~ss_n_in;
  assign starting   = running & ~run_prev;
  assign sck_toggle = running & (sck_in ^ sck_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      run_prev <= 1'b0;
    end else begin
      sck_prev <= sck_in;
      run_prev <= running;
    end
  end
endmodule

// File: rtl/sckwd_count.sv
module sckwd_count
  import sckwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_act_e          action,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             stopped,
  output logic             last_count,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign last_count = (count <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      stopped <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      unique case (action)
        WD_LOAD: begin
          count   <= reload;
          stopped <= 1'b0;
        end
        WD_HOLD: ;
        WD_DEC:  count <= count - ONE;
        WD_FIRE: begin
          count   <= '0;
          stopped <= 1'b1;
          fire    <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sck_watchdog.sv
module sck_watchdog
  import sckwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             wd_enable,
  input  logic             sck_sync,
  input  logic             ss_n_sync,
  input  logic [CNT_W-1:0] reload_val,
  output logic             timeout_pulse
);
  logic             armed;
  logic             running;
  logic             starting;
  logic             sck_toggle;
  logic             stopped;
  logic             last_count;
  logic [CNT_W-1:0] count;
  wd_act_e          action;
  logic             refresh;

  assign armed   = slave_mode & wd_enable;
  assign action  = pick_action(running, starting, stopped, sck_toggle,
                               (reload_val == '0), last_count);
  assign refresh = (action == WD_LOAD);

  sckwd_edges u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (armed),
    .sck_in     (sck_sync),
    .ss_n_in    (ss_n_sync),
    .running    (running),
    .starting   (starting),
    .sck_toggle (sck_toggle)
  );

  sckwd_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .action     (action),
    .reload     (reload_val),
    .count      (count),
    .stopped    (stopped),
    .last_count (last_count),
    .fire       (timeout_pulse)
  );
endmodule

// File: rtl/sck_watchdog_chk.sv
module sck_watchdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slave_mode,
  input logic             wd_enable,
  input logic             ss_n_sync,
  input logic [CNT_W-1:0] reload_val,
  input logic             timeout_pulse,
  input logic [CNT_W-1:0] count,
  input logic             stopped,
  input logic             refresh
);
  logic live;
  assign live = slave_mode & wd_enable & ~ss_n_sync;

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_sync |=> !timeout_pulse);

  assert_fire_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> ($past(count) <= CNT_W'(1)));

  assert_refresh_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (count == $past(reload_val)));

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  assert_quiet_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && live) |=> !timeout_pulse);

  assert_zero_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_val == '0) |=> !timeout_pulse);

  assert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (count == $past(reload_val) && !timeout_pulse));
endmodule

bind sck_watchdog sck_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .slave_mode    (slave_mode),
  .wd_enable     (wd_enable),
  .ss_n_sync     (ss_n_sync),
  .reload_val    (reload_val),
  .timeout_pulse (timeout_pulse),
  .count         (count),
  .stopped       (stopped),
  .refresh       (refresh)
);

// File: tb/sim_sck_watchdog.sv
`timescale 1ns/1ps
module sim_sck_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_mode = 1'b0;
  logic        wd_enable = 1'b0;
  logic        sck_sync = 1'b0;
  logic        ss_n_sync = 1'b1;
  logic [15:0] reload_val = 16'd20;
  logic        timeout_pulse;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";

  // behavioural model state
  int m_left = 0;
  bit m_done = 0;
  bit m_out = 0;
  bit m_was_on = 0;
  bit m_last_sck = 0;

  always #4 clk = ~clk;

  sck_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .wd_enable(wd_enable),
    .sck_sync(sck_sync), .ss_n_sync(ss_n_sync), .reload_val(reload_val),
    .timeout_pulse(timeout_pulse)
  );

  always @(posedge clk) begin
    bit on;
    bit moved;
    on = rst_n && slave_mode && wd_enable && !ss_n_sync;
    moved = (sck_sync != m_last_sck);
    m_out = 0;
    if (!rst_n) begin
      m_left = 0; m_done = 0;
    end else if (!on || !m_was_on) begin
      m_left = reload_val; m_done = 0;
    end else if (m_done) begin
      // waits for a new selection
    end else if (moved) begin
      m_left = reload_val;
    end else if (reload_val != 0) begin
      m_left = m_left - 1;
      if (m_left <= 0) begin m_left = 0; m_done = 1; m_out = 1; end
    end
    m_was_on = on;
    m_last_sck = rst_n ? sck_sync : 1'b0;
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) check(phase, timeout_pulse, m_out);

  // Runs n cycles, optionally toggling sck every 'gap' cycles; reports pulses
  // and the 1-based index of the first one.
  task automatic window(int n, int gap, output int pulses, output int first);
    pulses = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (timeout_pulse) begin
        pulses++;
        if (first == 0) first = i;
      end
      if (gap > 0 && (i % gap) == 0) sck_sync = ~sck_sync;
    end
  endtask

  initial begin
    int p, f;
    repeat (3) @(negedge clk);
    check("reset", timeout_pulse, 0);
    rst_n = 1'b1;
    slave_mode = 1'b1; wd_enable = 1'b1;

    phase = "R1"; // deselected, clock running
    window(60, 7, p, f); check("R1 pulses", p, 0);

    phase = "R2"; // selection with no clock activity
    ss_n_sync = 1'b0;
    window(40, 0, p, f); check("R2 pulses", p, 1); check("R2 first", f, 21);

    phase = "R5"; // clock after expiry gives nothing
    window(60, 5, p, f); check("R5 no repeat", p, 0);
    ss_n_sync = 1'b1; @(negedge clk);

    phase = "R3"; // edges every 15 cycles keep it alive; both kinds needed
    ss_n_sync = 1'b0;
    window(150, 15, p, f); check("R3/R4 alive", p, 0);
    window(40, 0, p, f); check("R3 after last edge", p, 1);
    check("R4 interval", f, 21 - (150 - 150/15*15 + 0) - 0 + 0);
    ss_n_sync = 1'b1; @(negedge clk);

    phase = "R4"; // one falling edge alone refreshes
    sck_sync = 1'b1; @(negedge clk);
    ss_n_sync = 1'b0;
    window(10, 0, p, f);
    sck_sync = 1'b0;
    window(40, 0, p, f); check("R4 falling refresh", f, 21);
    ss_n_sync = 1'b1; @(negedge clk);

    phase = "R6";
    reload_val = 16'd0; ss_n_sync = 1'b0;
    window(100, 0, p, f); check("R6 zero reload", p, 0);
    ss_n_sync = 1'b1; reload_val = 16'd20; @(negedge clk);

    phase = "R7";
    slave_mode = 1'b0; ss_n_sync = 1'b0;
    window(60, 0, p, f); check("R7 master mode", p, 0);
    slave_mode = 1'b1; wd_enable = 1'b0;
    window(60, 0, p, f); check("R7 disabled", p, 0);
    wd_enable = 1'b1;
    window(40, 0, p, f); check("R7 enable interval", f, 21);
    ss_n_sync = 1'b1; @(negedge clk);

    phase = "R8";
    ss_n_sync = 1'b0;
    window(15, 0, p, f); check("R8 partial", p, 0);
    ss_n_sync = 1'b1;
    window(30, 0, p, f); check("R8 released", p, 0);
    ss_n_sync = 1'b0;
    window(40, 0, p, f); check("R8 fresh interval", f, 21);

    phase = "R2";
    reload_val = 16'd3; ss_n_sync = 1'b1; @(negedge clk);
    ss_n_sync = 1'b0;
    window(10, 0, p, f); check("R2 short reload", f, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule